// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block sits on the host side of a four-wire SPI link to a serial NOR flash. A one-cycle request carries a command class, a 24-bit address and a byte count. The block then runs every bus frame that the command needs. It drives chip select and the serial clock, and it shifts out the opcode and the address. It inserts dummy clocks where the command needs them, then moves the data. Read bytes come back one at a time with a valid strobe, and a one-cycle done pulse ends the request.

Reads come in four kinds: plain, fast, dual-output and dual I/O. The dual kinds switch from one data line to two lines inside a single frame. A page program or an erase runs as a chain of frames. A write-enable frame comes first and the main frame follows. After that the block sends status-read frames until the flash reports that it is no longer busy. A programmable clock divider uses a slower serial clock for the plain read than for every other frame.

Top module: `spi_flash_host`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io0_oe and io1_oe are 0, and busy, done and rd_valid are 0.
- R2: req_cmd selects the command: 0 plain read, 1 fast read, 2 dual-output read, 3 dual I/O read, 4 page program, 5 4 KB sector erase, 6 32 KB block erase, 7 64 KB block erase. sck is 0 whenever cs_n is 1. Every byte is sent MSB first. The address is three bytes, high byte first.
- R3: A plain read sends opcode 03h and the address on io0. It then takes req_len bytes, one bit per clock from io1. The sck period is 2*SLOW_HALF clk cycles. Each byte appears on rd_data with a one-cycle rd_valid, in address order.
- R4: A fast read sends opcode 0Bh and the address, then 8 dummy clocks, then single-bit data on io1. The sck period is 2*FAST_HALF clk cycles. All other frames also use this period.
- R5: A dual-output read sends opcode 3Bh and the address on io0 alone, then 8 dummy clocks. Data then comes two bits per clock, with io1 carrying the higher bit of each pair. The block drives neither line from the first dummy clock to the end of the frame.
- R6: A dual I/O read sends opcode BBh on io0. It sends the address in 12 clocks of two bits each, with io1 carrying the higher bit, then 8 dummy clocks, then data as in R5. io1 is driven only during this address phase.
- R7: A page program first sends a frame holding only opcode 06h. A frame follows with opcode 02h, the address and data bytes taken from wr_data, with one wr_take pulse per byte consumed. The byte count is the smaller of req_len and 256 minus the low address byte.
- R8: An erase sends a 06h frame, then a 32-clock frame with opcode 20h, 52h or D8h for commands 5, 6 and 7. The address in that frame has its bits below bit 12, 15 or 16 cleared.
- R9: After the main frame of a program or erase, the block repeats 16-clock frames of opcode 05h followed by one status byte. It stops after the first status byte whose bit 0 is 0, and pulses done.
- R10: cs_n stays high for at least 2*FAST_HALF clk cycles between frames. busy is 1 from the cycle after a request is accepted until done. done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while busy is 0 |
| req_cmd | input | 3 | Command class (R2) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 9 | Byte count, 1 to 256 for program, 1 to 511 for reads |
| wr_data | input | 8 | Next program byte, held until wr_take |
| wr_take | output | 1 | Pulse: wr_data was consumed, present the next byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Pulse qualifying rd_data |
| done | output | 1 | Pulse at the end of a request |
| busy | output | 1 | Request in progress |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| io0_o | output | 1 | Data line 0 output value |
| io0_oe | output | 1 | Data line 0 output enable |
| io0_i | input | 1 | Data line 0 input |
| io1_o | output | 1 | Data line 1 output value |
| io1_oe | output | 1 | Data line 1 output enable |
| io1_i | input | 1 | Data line 1 input |

## Verification
The assertions assume that req_valid is raised only while busy is 0 and that req_len is never zero. They also assume that wr_data already holds the next byte whenever a program byte may be loaded. The bench keeps to this in three ways. It issues one request at a time and waits for done. It picks lengths of 1 or more. It drives wr_data combinationally from a counter that advances on each wr_take. A behavioural flash model replies only after the address and dummy clocks. It checks that the host has released both lines whenever the flash is driving them.

// File: rtl/spi_flash_host.sv
module spi_flash_host #(
  parameter int FAST_HALF = 1,
  parameter int SLOW_HALF = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_cmd,
  input  logic [23:0] req_addr,
  input  logic [8:0]  req_len,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done,
  output logic        busy,
  output logic        sck,
  output logic        cs_n,
  output logic        io0_o,
  output logic        io0_oe,
  input  logic        io0_i,
  output logic        io1_o,
  output logic        io1_oe,
  input  logic        io1_i
);
  localparam int HMAX = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int DW   = $clog2(HMAX + 1);

  localparam logic [2:0] C_READ = 3'd0, C_FAST = 3'd1, C_DOUT = 3'd2, C_DIO = 3'd3,
                         C_PROG = 3'd4, C_SE = 3'd5, C_BE32 = 3'd6, C_BE64 = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_LAUNCH, S_RUN, S_TAIL, S_GAP} st_t;
  typedef enum logic [1:0] {F_WREN, F_MAIN, F_POLL} fr_t;
  typedef enum logic [2:0] {P_OPC, P_ADDR, P_DUM, P_WDAT, P_RDAT, P_END} ph_t;

  st_t         st;
  fr_t         fr;
  ph_t         ph, nph, adv_ph;
  logic [2:0]  cmd, cib;
  logic [23:0] addr, addr_al;
  logic [8:0]  len, left, nleft, adv_left, rem, len_cl;
  logic [DW-1:0] divc, half;
  logic [7:0]  tx, rx, rx_nxt, opcode, load_byte;
  logic        sck_q, cs_q, bdone, stat_busy, gapn;
  logic        wide, tick, byte_last, is_fast, drive;

  assign is_fast   = (cmd == C_FAST) || (cmd == C_DOUT) || (cmd == C_DIO);
  assign wide      = (fr == F_MAIN) && (((ph == P_ADDR) && (cmd == C_DIO)) ||
                     ((ph == P_RDAT) && ((cmd == C_DOUT) || (cmd == C_DIO))));
  assign half      = ((fr == F_MAIN) && (cmd == C_READ)) ? DW'(SLOW_HALF) : DW'(FAST_HALF);
  assign tick      = (divc == half - 1'b1);
  assign byte_last = (cib == (wide ? 3'd3 : 3'd7));
  assign rx_nxt    = wide ? {rx[5:0], io1_i, io0_i} : {rx[6:0], io1_i};
  assign rem       = 9'd256 - {1'b0, req_addr[7:0]};
  assign len_cl    = ((req_cmd == C_PROG) && (req_len > rem)) ? rem : req_len;

  always_comb begin
    case (req_cmd)
      C_SE:    addr_al = {req_addr[23:12], 12'h000};
      C_BE32:  addr_al = {req_addr[23:15], 15'h0000};
      C_BE64:  addr_al = {req_addr[23:16], 16'h0000};
      default: addr_al = req_addr;
    endcase
  end

  always_comb begin
    opcode = 8'h05;
    if (fr == F_WREN) opcode = 8'h06;
    else if (fr == F_MAIN)
      case (cmd)
        C_READ:  opcode = 8'h03;
        C_FAST:  opcode = 8'h0B;
        C_DOUT:  opcode = 8'h3B;
        C_DIO:   opcode = 8'hBB;
        C_PROG:  opcode = 8'h02;
        C_SE:    opcode = 8'h20;
        C_BE32:  opcode = 8'h52;
        default: opcode = 8'hD8;
      endcase
  end

  always_comb begin
    nph = P_END;
    nleft = 9'd1;
    case (ph)
      P_OPC:
        if (fr == F_POLL) nph = P_RDAT;
        else if (fr == F_MAIN) begin nph = P_ADDR; nleft = 9'd3; end
      P_ADDR:
        if (is_fast) nph = P_DUM;
        else if (cmd == C_READ) begin nph = P_RDAT; nleft = len; end
        else if (cmd == C_PROG) begin nph = P_WDAT; nleft = len; end
      P_DUM: begin nph = P_RDAT; nleft = len; end
      default: ;
    endcase
  end

  assign adv_ph   = (left > 9'd1) ? ph : nph;
  assign adv_left = (left > 9'd1) ? left - 9'd1 : nleft;

  always_comb begin
    case (adv_ph)
      P_ADDR:  load_byte = (adv_left == 9'd3) ? addr[23:16] :
                           (adv_left == 9'd2) ? addr[15:8] : addr[7:0];
      P_WDAT:  load_byte = wr_data;
      default: load_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fr <= F_MAIN; ph <= P_OPC; cmd <= 3'd0; addr <= '0; len <= '0;
      left <= '0; cib <= '0; divc <= '0; tx <= '0; rx <= '0; sck_q <= 1'b0; cs_q <= 1'b1;
      bdone <= 1'b0; stat_busy <= 1'b0; gapn <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; wr_take <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      wr_take  <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            cmd  <= req_cmd;
            addr <= addr_al;
            len  <= len_cl;
            fr   <= req_cmd[2] ? F_WREN : F_MAIN;
            st   <= S_LAUNCH;
          end
        S_LAUNCH: begin
          cs_q <= 1'b0; ph <= P_OPC; left <= 9'd1; tx <= opcode;
          cib <= '0; divc <= '0; bdone <= 1'b0; st <= S_RUN;
        end
        S_RUN:
          if (!tick) divc <= divc + 1'b1;
          else begin
            divc <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx    <= rx_nxt;
              cib   <= cib + 3'd1;
              if (byte_last) begin
                cib   <= '0;
                bdone <= 1'b1;
                if (ph == P_RDAT) begin
                  if (fr == F_MAIN) begin rd_valid <= 1'b1; rd_data <= rx_nxt; end
                  else stat_busy <= rx_nxt[0];
                end
              end
            end else begin
              sck_q <= 1'b0;
              if (bdone) begin
                bdone <= 1'b0;
                if (adv_ph == P_END) st <= S_TAIL;
                else begin
                  ph   <= adv_ph;
                  left <= adv_left;
                  tx   <= load_byte;
                  if (adv_ph == P_WDAT) wr_take <= 1'b1;
                end
              end else
                tx <= wide ? {tx[5:0], 2'b00} : {tx[6:0], 1'b0};
            end
          end
        S_TAIL:
          if (!tick) divc <= divc + 1'b1;
          else begin divc <= '0; cs_q <= 1'b1; gapn <= 1'b0; st <= S_GAP; end
        S_GAP:
          if (!tick) divc <= divc + 1'b1;
          else begin
            divc <= '0;
            if (!gapn) gapn <= 1'b1;
            else begin
              case (fr)
                F_WREN: begin fr <= F_MAIN; st <= S_LAUNCH; end
                F_MAIN:
                  if (cmd[2]) begin fr <= F_POLL; st <= S_LAUNCH; end
                  else begin done <= 1'b1; st <= S_IDLE; end
                default:
                  if (stat_busy) st <= S_LAUNCH;
                  else begin done <= 1'b1; st <= S_IDLE; end
              endcase
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign drive  = (st == S_RUN) && ((ph == P_OPC) || (ph == P_ADDR) || (ph == P_WDAT));
  assign io0_oe = drive;
  assign io1_oe = drive && wide;
  assign io0_o  = wide ? tx[6] : tx[7];
  assign io1_o  = tx[7];
  assign sck    = sck_q;
  assign cs_n   = cs_q;
  assign busy   = (st != S_IDLE);

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  assert_cs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_io1_dio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io1_oe |-> (cmd == C_DIO && fr == F_MAIN && !cs_n));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr == F_MAIN && is_fast && !cs_n && (ph == P_DUM || ph == P_RDAT)) |-> (!io0_oe && !io1_oe));
  assert_take_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (cmd == C_PROG && !cs_n));
  assert_rdv_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!cs_n && !cmd[2]));
  assert_poll_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd[2]) |-> !stat_busy);
endmodule

// File: tb/spi_flash_host_tb.sv
module spi_flash_host_tb_top;
  localparam int FH = 1, SH = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [23:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [7:0] wd_bus, rd_data;
  logic wr_take, rd_valid, done, busy, sck, cs_n, io0_o, io0_oe, io1_o, io1_oe;
  logic r0 = 1'b0, r1 = 1'b0;
  logic io0_in, io1_in;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] wd(input int i);
    return 8'(i * 7 + 3);
  endfunction

  int tests = 0, fails = 0;
  int nf = 0, nrd = 0, nwt = 0, w0 = 0, poll_idx = 0, poll_base = 0, busy_need = 0;
  int cyc = 0, viol = 0, gapmin = 1000000, t_up = 0, t_r0 = 0, per = 0;
  int c = 0, ds, ac, k, bi, p, wcnt = 0;
  logic seen_up = 1'b0, cs_prev = 1'b1, sck_prev = 1'b0;
  logic [7:0] opc = '0, bv, wcur = '0;
  logic [23:0] fa = '0;
  logic [7:0] opc_l [0:63];
  logic [23:0] adr_l [0:63];
  int wc_l [0:63], ck_l [0:63], per_l [0:63];
  logic [7:0] rdbuf [0:511];
  logic [7:0] wmem [0:255];

  assign io0_in = io0_oe ? io0_o : r0;
  assign io1_in = io1_oe ? io1_o : r1;
  assign wd_bus = wd(nwt - w0);

  spi_flash_host #(.FAST_HALF(FH), .SLOW_HALF(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wd_bus), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .busy(busy), .sck(sck),
    .cs_n(cs_n), .io0_o(io0_o), .io0_oe(io0_oe), .io0_i(io0_in), .io1_o(io1_o),
    .io1_oe(io1_oe), .io1_i(io1_in));

  // behavioural flash model, sampled mid-cycle
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
    if (rd_valid) begin rdbuf[nrd & 511] = rd_data; nrd = nrd + 1; end
    if (wr_take) nwt = nwt + 1;
    if (cs_prev && !cs_n) begin
      c = 0; opc = '0; fa = '0; wcnt = 0; r0 = 1'b0; r1 = 1'b0; per = 0;
      if (seen_up && (cyc - t_up) < gapmin) gapmin = cyc - t_up;
    end
    ac = (opc == 8'hBB) ? 12 : 24;
    if (!cs_n && sck && !sck_prev) begin
      if (c == 0) t_r0 = cyc;
      if (c == 1) per = cyc - t_r0;
      if (c < 8) opc = {opc[6:0], io0_in};
      else if (c < 8 + ac && opc != 8'h05 && opc != 8'h06) begin
        if (opc == 8'hBB) fa = {fa[21:0], io1_in, io0_in};
        else fa = {fa[22:0], io0_in};
      end else if (opc == 8'h02 && c >= 32) begin
        wcur = {wcur[6:0], io0_in};
        if ((c - 32) % 8 == 7) begin wmem[wcnt & 255] = wcur; wcnt = wcnt + 1; end
      end
      if (c >= 8 + ac && (opc == 8'h3B || opc == 8'hBB) && (io0_oe || io1_oe)) viol = viol + 1;
      if (opc != 8'hBB && c >= 8 && io1_oe) viol = viol + 1;
      c = c + 1;
    end
    if (!cs_n && !sck && sck_prev) begin
      ds = (opc == 8'h05) ? 8 : 8 + ac + ((opc == 8'h0B || opc == 8'h3B || opc == 8'hBB) ? 8 : 0);
      if ((opc == 8'h03 || opc == 8'h0B || opc == 8'h3B || opc == 8'hBB || opc == 8'h05) && c >= ds) begin
        k = c - ds;
        if (opc == 8'h3B || opc == 8'hBB) begin
          bi = k / 4; p = 3 - (k % 4);
          bv = pat(fa + 24'(bi));
          r1 = bv[2*p+1]; r0 = bv[2*p];
        end else begin
          bi = k / 8;
          if (opc == 8'h05) bv = ((poll_idx - poll_base) < busy_need) ? 8'h03 : 8'h02;
          else bv = pat(fa + 24'(bi));
          r1 = bv[7 - (k % 8)];
        end
      end
    end
    if (!cs_prev && cs_n) begin
      opc_l[nf & 63] = opc; adr_l[nf & 63] = fa; wc_l[nf & 63] = wcnt;
      ck_l[nf & 63] = c; per_l[nf & 63] = per;
      nf = nf + 1;
      if (opc == 8'h05) poll_idx = poll_idx + 1;
      t_up = cyc; seen_up = 1'b1;
    end
    cs_prev = cs_n; sck_prev = sck;
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int f0, rb, v0;
  task automatic do_op(input logic [2:0] cm, input logic [23:0] ad, input logic [8:0] ln, input int bn);
    int t;
    busy_need = bn; poll_base = poll_idx; f0 = nf; rb = nrd; w0 = nwt; v0 = viol;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cm; req_addr = ad; req_len = ln;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", longint'(busy), 1);
    t = 0;
    while (!done && t < 40000) begin @(negedge clk); t = t + 1; end
    check(done == 1'b1, "R10 done reached", longint'(done), 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10 done single pulse", longint'({done, busy}), 0);
  endtask

  logic [7:0] rops [0:3];
  logic [7:0] eops [0:2];
  logic [23:0] eadr [0:2];
  logic [23:0] sad [0:2];
  int slen [0:2];
  int bad, expn;

  initial begin
    rops[0] = 8'h03; rops[1] = 8'h0B; rops[2] = 8'h3B; rops[3] = 8'hBB;
    eops[0] = 8'h20; eops[1] = 8'h52; eops[2] = 8'hD8;
    eadr[0] = 24'hABC000; eadr[1] = 24'hAB8000; eadr[2] = 24'hAB0000;
    sad[0] = 24'h000000; sad[1] = 24'h12345F; sad[2] = 24'hFFFFFE;
    slen[0] = 1; slen[1] = 3; slen[2] = 6;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0 && !io0_oe && !io1_oe && !busy && !done && !rd_valid,
          "R1 reset idle", longint'({cs_n, sck, io0_oe, io1_oe, busy, done, rd_valid}), 7'b1000000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // read sweep: R2 R3 R4 R5 R6
    for (int cm = 0; cm < 4; cm++)
      for (int ai = 0; ai < 3; ai++)
        for (int li = 0; li < 3; li++) begin
          do_op(3'(cm), sad[ai], 9'(slen[li]), 0);
          check(nf - f0 == 1, "R2 one frame per read", nf - f0, 1);
          check(opc_l[f0 & 63] == rops[cm], "R2 read opcode", opc_l[f0 & 63], rops[cm]);
          check(adr_l[f0 & 63] == sad[ai], "R2 address MSB first", adr_l[f0 & 63], sad[ai]);
          check(nrd - rb == slen[li], "R3 byte count", nrd - rb, slen[li]);
          bad = 0;
          for (int i = 0; i < slen[li]; i++)
            if (rdbuf[(rb + i) & 511] != pat(sad[ai] + 24'(i))) bad = bad + 1;
          if (cm == 0) check(bad == 0, "R3 plain read data", bad, 0);
          if (cm == 1) check(bad == 0, "R4 fast read data after dummy", bad, 0);
          if (cm == 2) check(bad == 0, "R5 dual output data order", bad, 0);
          if (cm == 3) check(bad == 0, "R6 dual io data order", bad, 0);
          expn = (cm == 0) ? 2 * SH : 2 * FH;
          check(per_l[f0 & 63] == expn, (cm == 0) ? "R3 slow sck period" : "R4 fast sck period",
                per_l[f0 & 63], expn);
          check(viol == v0, "R5 R6 line release", viol - v0, 0);
        end

    // program crossing page end: clamp to 16, three busy polls  (R7 R9)
    do_op(3'd4, 24'h0012F0, 9'd32, 3);
    check(nf - f0 == 6, "R9 frames for program with 3 busy polls", nf - f0, 6);
    check(opc_l[f0 & 63] == 8'h06 && ck_l[f0 & 63] == 8, "R7 write enable frame",
          {opc_l[f0 & 63], 8'(ck_l[f0 & 63])}, 16'h0608);
    check(opc_l[(f0 + 1) & 63] == 8'h02, "R7 program opcode", opc_l[(f0 + 1) & 63], 8'h02);
    check(adr_l[(f0 + 1) & 63] == 24'h0012F0, "R7 program address", adr_l[(f0 + 1) & 63], 24'h0012F0);
    check(wc_l[(f0 + 1) & 63] == 16, "R7 clamp to page end", wc_l[(f0 + 1) & 63], 16);
    check(nwt - w0 == 16, "R7 wr_take count", nwt - w0, 16);
    bad = 0;
    for (int i = 0; i < 16; i++) if (wmem[i] != wd(i)) bad = bad + 1;
    check(bad == 0, "R7 program data", bad, 0);
    bad = 0;
    for (int i = 2; i < 6; i++)
      if (opc_l[(f0 + i) & 63] != 8'h05 || ck_l[(f0 + i) & 63] != 16) bad = bad + 1;
    check(bad == 0, "R9 status poll frames", bad, 0);

    // full page program, flash idle at first poll
    do_op(3'd4, 24'h004500, 9'd256, 0);
    check(nf - f0 == 3, "R9 single poll when not busy", nf - f0, 3);
    check(wc_l[(f0 + 1) & 63] == 256, "R7 full page", wc_l[(f0 + 1) & 63], 256);
    bad = 0;
    for (int i = 0; i < 256; i++) if (wmem[i] != wd(i)) bad = bad + 1;
    check(bad == 0, "R7 full page data", bad, 0);

    // last byte of page: one byte only
    do_op(3'd4, 24'h0000FF, 9'd5, 1);
    check(wc_l[(f0 + 1) & 63] == 1 && nwt - w0 == 1, "R7 clamp at last page byte",
          wc_l[(f0 + 1) & 63], 1);
    check(nf - f0 == 4, "R9 one busy poll", nf - f0, 4);

    // erases with address alignment (R8 R9)
    for (int e = 0; e < 3; e++) begin
      do_op(3'(5 + e), 24'hABCDEF, 9'd1, 2);
      check(nf - f0 == 5, "R9 erase poll count", nf - f0, 5);
      check(opc_l[f0 & 63] == 8'h06, "R8 write enable before erase", opc_l[f0 & 63], 8'h06);
      check(opc_l[(f0 + 1) & 63] == eops[e], "R8 erase opcode", opc_l[(f0 + 1) & 63], eops[e]);
      check(adr_l[(f0 + 1) & 63] == eadr[e], "R8 erase alignment", adr_l[(f0 + 1) & 63], eadr[e]);
      check(ck_l[(f0 + 1) & 63] == 32 && nrd == rb, "R8 erase frame length", ck_l[(f0 + 1) & 63], 32);
    end

    check(gapmin >= 2 * FH, "R10 chip select gap", gapmin, 2 * FH);
    check(cs_n == 1'b1 && sck == 1'b0, "R2 idle bus after run", longint'({cs_n, sck}), 2'b10);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule